// File: doc/BRIEF.md
# Chainable SPI Shift Stage

This block is a serial slave stage for a chain of identical stages that share one active-low select. Each stage's serial output feeds the serial input of the next stage. While the select is low, the stage takes in one bit on every rising edge of the serial clock. It shifts its register on the falling edge, so its output plays back the incoming stream exactly one word later. A host that clocks k words through a chain of k stages with one select pulse leaves one word in each stage.

The serial clock, data input and select are brought into the system clock domain through two flip-flops each. Edges of the serial clock are then detected synchronously, so the serial clock must run slower than a quarter of the system clock. A small state machine tracks the select and has three states:
- **IDLE**: not selected.
- **SHIFT**: selected and shifting.
- **LATCH**: lasts one cycle after release.

The transitions are:
- IDLE to SHIFT when the synchronized select goes low.
- SHIFT to LATCH when it goes high.
- LATCH to IDLE unconditionally.

On leaving SHIFT, the register is copied to a parallel word output, and a strobe is high during LATCH.

Top module: `chain_shift_stage`

## Requirements
- R1: While the stage is not selected, `sdo_en` and `sdo` are 0, and toggling `sclk` or `sdi` leaves the stored word, the parallel output and the strobe unchanged.
- R2: Clock mode 0 is used. `sdi` is sampled on the rising `sclk` edge and `sdo` changes after the falling edge. The first output bit of a frame is present before the first rising edge.
- R3: Data moves most significant bit first. The bit on `sdo` before a rising edge is the bit received `WORD_W` rising edges earlier, so a group of `WORD_W` clocks replays the previous group exactly.
- R4: Forwarding goes on for any number of clocks while the select stays low, including frames longer than one word.
- R5: A rising select loads `word_out` with the last `WORD_W` bits shifted in, the first of them in bit `WORD_W-1`. `word_valid` is high for exactly one clock per frame, and `word_out` changes at no other time.
- R6: A frame whose bit count is not a multiple of `WORD_W` still leaves the last `WORD_W` bits received in the register and in `word_out`. Any remaining positions hold older bits.
- R7: Two stages in a chain on one select, clocked with 2×`WORD_W` bits, end with the first word in the far stage and the second word in the near stage.
- R8: After reset, the stored word and `word_out` are 0, `word_valid` and `sdo_en` are 0, and the first frame sends out zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| sel_n | input | 1 | Active-low select shared by the chain |
| sdi | input | 1 | Serial data in (host or previous stage) |
| sdo | output | 1 | Serial data out to the next stage, 0 when not selected |
| sdo_en | output | 1 | High while the stage drives `sdo` |
| word_out | output | WORD_W | Word captured at the last select release |
| word_valid | output | 1 | One-clock strobe when `word_out` is loaded |

## Verification
The bench runs two stages wired as a chain on one select. Whole-word frames separate a correct one-word delay from an off-by-one delay or reversed bit order. Short and odd-length frames expose whether the register keeps the last `WORD_W` bits or resets its position. A frame of three words shows that forwarding does not stop after one word. Clock and data activity while deselected shows whether the select gates the shifter. Random frame lengths and data, checked against a reference shift model, mix all of these patterns.

// File: rtl/chain_stage_pkg.sv
package chain_stage_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } stage_state_t;

endpackage

// File: rtl/chain_sync.sv
module chain_sync #(
    parameter int               WIDTH   = 3,
    parameter int               DEPTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[DEPTH-1];

endmodule

// File: rtl/chain_stage_fsm.sv
module chain_stage_fsm
    import chain_stage_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    output logic active,
    output logic load,
    output logic valid
);

    stage_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!sel_s) state_d = ST_SHIFT;
            ST_SHIFT: if (sel_s)  state_d = ST_LATCH;
            ST_LATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active = 1'b0;
        load   = 1'b0;
        valid  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SHIFT: begin
                active = 1'b1;
                load   = sel_s;
            end
            ST_LATCH: valid = 1'b1;
            default:  ;
        endcase
    end

    // R1: shifting is only possible after the select was seen low
    p_en_after_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !$past(sel_s));

    // R5: strobe lasts a single clock
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/chain_shifter.sv
module chain_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              sdo_bit,
    output logic [WORD_W-1:0] word_out
);

    localparam int MSB = WORD_W - 1;

    logic              sclk_q;
    logic              cap_q;
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] word_q;
    logic              rise, fall;

    assign rise = active &  sclk_s & ~sclk_q;
    assign fall = active & ~sclk_s &  sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            cap_q   <= 1'b0;
            shreg_q <= '0;
            word_q  <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (rise) cap_q   <= sdi_s;
            if (fall) shreg_q <= {shreg_q[MSB-1:0], cap_q};
            if (load) word_q  <= shreg_q;
        end
    end

    assign sdo_bit  = shreg_q[MSB];
    assign word_out = word_q;

    // R1: register untouched while the stage is not shifting
    p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(shreg_q));

endmodule

// File: rtl/chain_shift_stage.sv
module chain_shift_stage #(
    parameter int WORD_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sel_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    logic [2:0] sync_q;
    logic       sel_s, sclk_s, sdi_s;
    logic       active, load, sdo_bit;

    chain_sync #(
        .WIDTH  (3),
        .DEPTH  (SYNC_DEPTH),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sel_n, sclk, sdi}),
        .q    (sync_q)
    );

    assign sel_s  = sync_q[2];
    assign sclk_s = sync_q[1];
    assign sdi_s  = sync_q[0];

    chain_stage_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_s (sel_s),
        .active(active),
        .load  (load),
        .valid (word_valid)
    );

    chain_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .load    (load),
        .sclk_s  (sclk_s),
        .sdi_s   (sdi_s),
        .sdo_bit (sdo_bit),
        .word_out(word_out)
    );

    assign sdo_en = active;
    assign sdo    = active & sdo_bit;

    // R5: parallel word moves only together with the strobe
    p_word_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_out != $past(word_out)) |-> word_valid);

    // R5: strobe follows a released select
    p_strobe_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(sel_s));

endmodule

// File: tb/chain_shift_stage_bench.sv
module chain_shift_stage_bench;

    localparam int W = 8;
    localparam int H = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sel_n = 1'b1;
    logic         sdi = 1'b0;
    logic         sdo1, sdo2, en1, en2, v1, v2;
    logic [W-1:0] wo1, wo2;

    int checks = 0;
    int errors = 0;
    int vcnt1 = 0, vcnt2 = 0, dbl = 0;
    logic pv1 = 1'b0;
    logic [W-1:0] m1 = '0, m2 = '0;

    always #10 clk = ~clk;

    chain_shift_stage #(.WORD_W(W)) u_chain_shift_stage (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
        .sdo(sdo1), .sdo_en(en1), .word_out(wo1), .word_valid(v1)
    );

    chain_shift_stage #(.WORD_W(W)) u_chain_shift_stage_b (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdo1),
        .sdo(sdo2), .sdo_en(en2), .word_out(wo2), .word_valid(v2)
    );

    always @(negedge clk) begin
        if (v1) vcnt1++;
        if (v2) vcnt2++;
        if (v1 && pv1) dbl++;
        pv1 <= v1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] push(input logic [W-1:0] m, input logic b);
        return {m[W-2:0], b};
    endfunction

    task automatic send_frame(input int n, input logic [95:0] v);
        int c1, c2;
        logic b, o1, o2;
        c1 = vcnt1;
        c2 = vcnt2;
        @(negedge clk);
        sel_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            b   = v[n-1-i];
            sdi = b;
            repeat (H) @(negedge clk);
            o1 = m1[W-1];
            o2 = m2[W-1];
            check(sdo1 === o1, (i == 0) ? "R2 first bit" : (i >= W ? "R4 stage1 sdo" : "R3 stage1 sdo"),
                  int'(sdo1), int'(o1));
            check(sdo2 === o2, "R7 stage2 sdo", int'(sdo2), int'(o2));
            if (i == 0) check(en1 === 1'b1, "R1 enable when selected", int'(en1), 1);
            sclk = 1'b1;
            m2 = push(m2, o1);
            m1 = push(m1, b);
            repeat (H) @(negedge clk);
            sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        sel_n = 1'b1;
        repeat (10) @(negedge clk);
        check(wo1 === m1, (n % W != 0) ? "R6 odd frame word" : "R5 stage1 word", int'(wo1), int'(m1));
        check(wo2 === m2, "R7 stage2 word", int'(wo2), int'(m2));
        check(vcnt1 == c1 + 1, "R5 one strobe stage1", vcnt1 - c1, 1);
        check(vcnt2 == c2 + 1, "R5 one strobe stage2", vcnt2 - c2, 1);
        check(en1 === 1'b0 && sdo1 === 1'b0, "R1 released idle", int'({en1, sdo1}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R8 reset state
        check(wo1 === '0 && wo2 === '0, "R8 word after reset", int'(wo1), 0);
        check(v1 === 1'b0 && en1 === 1'b0 && sdo1 === 1'b0, "R8 outputs after reset",
              int'({v1, en1, sdo1}), 0);

        send_frame(W, 96'hA5);             // R8 shifts out zeros, R5 latch
        send_frame(W, 96'h3C);             // R3 replay of previous word
        send_frame(2 * W, 96'h5A96);       // R7 two words through the chain
        send_frame(11, 96'h6D3);           // R6 odd length
        send_frame(3, 96'h5);              // R6 short frame
        send_frame(3 * W, 96'hF00FC3);     // R4 long frame

        // R1 activity while deselected is ignored
        begin
            int c1;
            logic [W-1:0] w1;
            c1 = vcnt1;
            w1 = wo1;
            for (int k = 0; k < 12; k++) begin
                sdi = 1'($urandom);
                sclk = 1'b1;
                repeat (H) @(negedge clk);
                check(en1 === 1'b0 && sdo1 === 1'b0, "R1 no drive deselected", int'({en1, sdo1}), 0);
                sclk = 1'b0;
                repeat (H) @(negedge clk);
            end
            check(wo1 === w1, "R1 word unchanged", int'(wo1), int'(w1));
            check(vcnt1 == c1, "R1 no strobe", vcnt1 - c1, 0);
        end
        send_frame(W, 96'h81);             // R1 stored contents survived

        for (int r = 0; r < 30; r++) begin
            send_frame($urandom_range(1, 20), {$urandom, $urandom, $urandom});
        end

        check(dbl == 0, "R5 strobe width", dbl, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule